// File: doc/BRIEF.md
# Output Port Set/Clear Register

This block keeps a general-purpose output word, eight bits wide by default, inside a serial peripheral. A host bus controls it. The whole word is never written in one access. The host changes single bits through two command addresses. A write to the set address puts a 1 in every register bit whose data bit is 1. A write to the clear address puts a 0 in every register bit whose data bit is 1. Data bits that are 0 leave their register bits as they were.

Each register bit drives its output pin through an inverter, so a pin always shows the complement of its bit. A separate read-only port shows the register value, which lets a model outside the block follow every update.

Top module: `opreg_top`

## Requirements
- R1: A synchronous active-high reset puts the register at 0x00, which drives every pin high (0xFF).
- R2: In every cycle, pin n equals the inverse of register bit n, for every n.
- R3: A write strobe with address 0x0E (set command) makes register bit n equal 1 wherever data bit n is 1, on the clock edge of the strobe.
- R4: A write strobe with address 0x0F (clear command) makes register bit n equal 0 wherever data bit n is 1, on the clock edge of the strobe.
- R5: During a set or clear command, each register bit whose data bit is 0 keeps its value.
- R6: A write strobe to any address other than 0x0E or 0x0F leaves the register unchanged. A set or clear address with the strobe low also leaves it unchanged.
- R7: The readback port shows the register value. It changes in the cycle after the command edge, at the same time as the pins.
- R8: With the register at 0xFF, a clear command with data 0xF0 leaves the register at 0x0F and the pins at 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data, used as a mask |
| port_pins | output | 8 | Output pins, the inverse of the register |
| port_state | output | 8 | Readback of the register value |

## Verification
A wrong register bit shows at both ports one cycle after the command edge that caused it: the readback shows the bit and the pin shows its inverse. If the state and the pins disagree, the check catches it in the same cycle. An address decode error shows as a change after a write to a foreign address, or as no change after a command. The bench therefore reads both ports after every write and compares them with its own model of the register.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SET   = 2'd1,
    CMD_CLEAR = 2'd2
  } opreg_cmd_e;
endpackage

// File: rtl/opreg_decode.sv
module opreg_decode
  import opreg_pkg::*;
#(
  parameter int AW = 4,
  parameter logic [AW-1:0] SET_ADDR = 4'hE,
  parameter logic [AW-1:0] CLR_ADDR = 4'hF
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  output opreg_cmd_e    cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (we) begin
      if (addr == SET_ADDR)      cmd = CMD_SET;
      else if (addr == CLR_ADDR) cmd = CMD_CLEAR;
    end
  end

  always_comb begin
    a_r6_decode_onehot: assert ($onehot0({cmd == CMD_SET, cmd == CMD_CLEAR}));
  end
endmodule

// File: rtl/opreg_bits.sv
module opreg_bits
  import opreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  opreg_cmd_e   cmd,
  input  logic [W-1:0] mask,
  output logic [W-1:0] state
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                               state[i] <= 1'b0;
      else if (cmd == CMD_SET   && mask[i])  state[i] <= 1'b1;
      else if (cmd == CMD_CLEAR && mask[i])  state[i] <= 1'b0;
    end
  end

  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SET) |=> ((state & $past(mask)) == $past(mask)));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLEAR) |=> ((state & $past(mask)) == '0));
  a_r5_zero_mask_keeps: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NONE) |=> ((state & ~$past(mask)) == ($past(state) & ~$past(mask))));
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> $stable(state));
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (state == '0));
endmodule

// File: rtl/opreg_drive.sv
module opreg_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] state,
  output logic [W-1:0] pins,
  output logic [W-1:0] rdback
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pins[i]   = ~state[i];
    assign rdback[i] = state[i];
  end

  always_comb begin
    a_r2_pins_inverted: assert ((pins ^ rdback) == {W{1'b1}});
  end
endmodule

// File: rtl/opreg_top.sv
module opreg_top
  import opreg_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] SET_ADDR = 4'hE,
  parameter logic [AW-1:0] CLR_ADDR = 4'hF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  port_pins,
  output logic [W-1:0]  port_state
);
  opreg_cmd_e   cmd;
  logic [W-1:0] state_q;

  opreg_decode #(.AW(AW), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
    .we(bus_we), .addr(bus_addr), .cmd(cmd)
  );

  opreg_bits #(.W(W)) u_bits (
    .clk(clk), .rst(rst), .cmd(cmd), .mask(bus_wdata), .state(state_q)
  );

  opreg_drive #(.W(W)) u_drv (
    .state(state_q), .pins(port_pins), .rdback(port_state)
  );

  a_r7_readback_follows: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == SET_ADDR) |=> ((port_state & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

// File: tb/opreg_top_test.sv
module opreg_top_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] pins, st;
  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] model;

  always #2 clk = ~clk;

  opreg_top uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .port_pins(pins), .port_state(st)
  );

  // vector: {we, addr, data, expected state}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'hE, 8'hA5, 8'hA5},  // R3 set
    {1'b1, 4'hE, 8'h00, 8'hA5},  // R5 zero mask
    {1'b1, 4'hF, 8'h05, 8'hA0},  // R4 clear
    {1'b1, 4'hD, 8'hFF, 8'hA0},  // R6 foreign address
    {1'b0, 4'hE, 8'hFF, 8'hA0},  // R6 no strobe
    {1'b1, 4'hE, 8'h0F, 8'hAF},  // R3/R5
    {1'b1, 4'hF, 8'h00, 8'hAF},  // R5
    {1'b1, 4'h0, 8'h00, 8'hAF},  // R6
    {1'b0, 4'hF, 8'hFF, 8'hAF},  // R6
    {1'b1, 4'hF, 8'hAA, 8'h05},  // R4
    {1'b1, 4'hE, 8'hFF, 8'hFF},  // R3
    {1'b1, 4'hF, 8'hF0, 8'h0F}   // R8 worked case
  };

  task automatic check(input string req, input logic [7:0] exp_st);
    n_run++;
    if (st !== exp_st || pins !== ~exp_st) begin
      n_fail++;
      $display("FAIL %s: state=%h pins=%h expected state=%h pins=%h",
               req, st, pins, exp_st, ~exp_st);
    end
  endtask

  task automatic wr(input logic w, input logic [3:0] a, input logic [7:0] d);
    we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 reset", 8'h00);
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
      check("R3/R4/R5/R6/R7/R8 vector", VEC[i][7:0]);
    end
    // R7: unchanged before the edge, updated right after it
    we = 1'b1; addr = 4'hF; wdata = 8'h0F; #1;
    check("R7 no change before edge", 8'h0F);
    @(posedge clk); #1; we = 1'b0;
    check("R7 after edge", 8'h00);
    // R2: pins are the complement at every readable pattern
    wr(1'b1, 4'hE, 8'h3C);
    check("R2 complement", 8'h3C);
    // R6: every foreign address with a full mask
    for (int a = 0; a < 14; a++) begin
      wr(1'b1, 4'(a), 8'hFF);
      check("R6 foreign addr", 8'h3C);
    end
    // R1: reset mid-run
    rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    check("R1 reset again", 8'h00);
    model = 8'h00;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule